// File: doc/BRIEF.md
# Console Port Controller with Pointer-Indexed Status

This block is a small console controller that a host reaches through a byte-wide bus with separate read and write strobes. Only two bus offsets do anything. One is a control/status register. The other is a data register. Every other offset reads zero, and writes to those offsets have no effect. Bytes written to the data register go out on a transmit stream. Bytes that arrive on a receive stream are held in a small FIFO until the host reads them through the data register. A single interrupt output tells the host that something needs attention.

Status readback works through a register pointer. A write to the control register stores the written byte as the pointer. A status read with the pointer at 3 returns a code for the interrupt source and then sets the pointer back to 0. A status read with any other pointer value returns a plain line-status byte. Each transmit write raises a transmit interrupt. That interrupt stays up until the host writes the acknowledge command 0x28 to the control register. Each byte that arrives raises a receive interrupt with no enable gating. The receive interrupt drops when a data read leaves the FIFO empty. Misuse does not stall the bus. An acknowledge with no transmit interrupt pending, a data read from an empty FIFO, or a byte that arrives while the FIFO is full each produce a one-cycle error pulse.

Top module: `console_port_ctrl`

## Requirements
- R1: After reset, `irq_o`, `err_o` and `tx_valid_o` are 0, the pointer is 0, both pending flags are clear and the FIFO is empty, so a status read returns 0x04.
- R2: A write to offset 0x80 stores the byte as the pointer. Values such as 0x00, 0x01, 0x12 and other commands have no further side effect. A status read with the pointer at 3 sets the pointer back to 0.
- R3: A status read with the pointer at 3 returns 0x10 if a transmit interrupt is pending. Otherwise it returns 0x20 if a receive interrupt is pending. Otherwise it returns 0x00.
- R4: A status read with any pointer other than 3 returns 0x04, with bit 0 set when a receive interrupt is pending.
- R5: A write to offset 0xC0 produces, on the next cycle, a one-cycle `tx_valid_o` with `tx_data_o` equal to the written byte. The same write sets transmit-pending and asserts `irq_o`.
- R6: Writing 0x28 to offset 0x80 clears transmit-pending and deasserts `irq_o`, even while a receive interrupt is pending. If no transmit interrupt was pending, `err_o` pulses for one cycle.
- R7: Each cycle with `rx_valid_i` high sets receive-pending and asserts `irq_o` on the next cycle.
- R8: A read of offset 0xC0 returns the oldest received byte, in arrival order. If that read empties the FIFO, receive-pending clears and `irq_o` deasserts. If bytes remain, both stay set.
- R9: A read of offset 0xC0 with the FIFO empty returns 0x00, pulses `err_o`, clears receive-pending and deasserts `irq_o`.
- R10: A read of any offset other than 0x80 or 0xC0 returns 0x00. A write to such an offset changes no state and produces no transmit.
- R11: A byte that arrives while the FIFO holds `RX_DEPTH` bytes (4 by default) is dropped and pulses `err_o`. It still sets receive-pending. A pop in the same cycle makes room for the byte.
- R12: When a set event (transmit write or byte arrival) and a clear event (acknowledge or emptying read) happen in the same cycle, the set event wins, so `irq_o` stays asserted.
- R13: Read data appears on `rdata_o` in the cycle after the read strobe. In every cycle without a read, `rdata_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Bus offset |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Registered read data |
| rx_valid_i | input | 1 | A received byte is present this cycle |
| rx_data_i | input | 8 | Received byte |
| tx_valid_o | output | 1 | Transmit byte strobe |
| tx_data_o | output | 8 | Transmit byte |
| irq_o | output | 1 | Interrupt request |
| err_o | output | 1 | One-cycle misuse pulse |

## Verification
Directed sequences cover the cases one at a time. These are a transmit with no receive traffic, received bytes with no transmit, and both sources pending together. Comparing the results shows whether the pointer-3 code applies transmit-over-receive priority and whether an acknowledge leaves a pending receive alone. Further sequences fill the FIFO to overflow, read it back to empty and past empty, and pair an arrival with the emptying read in one cycle. These show arrival order, the error pulse, and the rule that a set event beats a clear event. A pseudo-random run then mixes strobes, offsets, commands and arrivals against a behavioural queue model on every clock. That run reaches orderings that the directed sequences miss.

// File: rtl/cnsl_pkg.sv
package cnsl_pkg;
  localparam int unsigned BUS_W = 8;
  localparam logic [BUS_W-1:0] OFS_CTRL   = 8'h80;
  localparam logic [BUS_W-1:0] OFS_DATA   = 8'hC0;
  localparam logic [BUS_W-1:0] CMD_TX_ACK = 8'h28;
  localparam logic [BUS_W-1:0] PTR_ISRC   = 8'h03;
  localparam logic [BUS_W-1:0] ISRC_TX    = 8'h10;
  localparam logic [BUS_W-1:0] ISRC_RX    = 8'h20;
  localparam logic [BUS_W-1:0] LSTAT_BASE = 8'h04;
endpackage

// File: rtl/cnsl_rx_fifo.sv
module cnsl_rx_fifo #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  output logic [DW-1:0] head_o,
  output logic [CW-1:0] count_o,
  output logic          drop_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;
  logic          empty, full, do_pop, do_push;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign do_pop  = pop_i && !empty;
  assign do_push = push_i && (!full || do_pop);
  assign drop_o  = push_i && !do_push;
  assign head_o  = mem_q[rd_ptr_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= nxt(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= nxt(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[i] <= '0;
      else if (do_push && wr_ptr_q == AW'(i)) mem_q[i] <= push_data_i;
    end
  end
endmodule

// File: rtl/cnsl_pend_ctrl.sv
module cnsl_pend_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_set_i,
  input  logic tx_ack_i,
  input  logic rx_set_i,
  input  logic rx_clr_i,
  output logic tx_pend_o,
  output logic rx_pend_o,
  output logic irq_o,
  output logic ack_err_o
);
  logic tx_q, rx_q, irq_q;

  assign ack_err_o = tx_ack_i && !tx_q;

  // set events win over clear events in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q  <= 1'b0;
      rx_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (tx_set_i)      tx_q <= 1'b1;
      else if (tx_ack_i) tx_q <= 1'b0;
      if (rx_set_i)      rx_q <= 1'b1;
      else if (rx_clr_i) rx_q <= 1'b0;
      if (tx_set_i || rx_set_i)      irq_q <= 1'b1;
      else if (tx_ack_i || rx_clr_i) irq_q <= 1'b0;
    end
  end

  assign tx_pend_o = tx_q;
  assign rx_pend_o = rx_q;
  assign irq_o     = irq_q;
endmodule

// File: rtl/cnsl_rd_mux.sv
module cnsl_rd_mux
  import cnsl_pkg::*;
(
  input  logic [BUS_W-1:0] addr_i,
  input  logic [BUS_W-1:0] ptr_i,
  input  logic             tx_pend_i,
  input  logic             rx_pend_i,
  input  logic             fifo_empty_i,
  input  logic [BUS_W-1:0] fifo_head_i,
  output logic [BUS_W-1:0] rdata_o
);
  logic [BUS_W-1:0] stat;

  always_comb begin
    if (ptr_i == PTR_ISRC) begin
      if (tx_pend_i)      stat = ISRC_TX;
      else if (rx_pend_i) stat = ISRC_RX;
      else                stat = '0;
    end else begin
      stat = LSTAT_BASE | {{(BUS_W-1){1'b0}}, rx_pend_i};
    end
  end

  always_comb begin
    unique case (addr_i)
      OFS_CTRL: rdata_o = stat;
      OFS_DATA: rdata_o = fifo_empty_i ? '0 : fifo_head_i;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/console_port_ctrl.sv
module console_port_ctrl
  import cnsl_pkg::*;
#(
  parameter int unsigned RX_DEPTH = 4,
  localparam int unsigned CNT_W   = $clog2(RX_DEPTH + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] addr_i,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  input  logic       rd_i,
  output logic [7:0] rdata_o,
  input  logic       rx_valid_i,
  input  logic [7:0] rx_data_i,
  output logic       tx_valid_o,
  output logic [7:0] tx_data_o,
  output logic       irq_o,
  output logic       err_o
);
  logic [BUS_W-1:0] ptr_q, rd_val, fifo_head;
  logic [CNT_W-1:0] rx_cnt;
  logic             wr_ctrl, wr_data, rd_ctrl, rd_data;
  logic             tx_ack, rx_clr, fifo_empty, fifo_drop;
  logic             tx_pend, rx_pend, ack_err;

  assign wr_ctrl    = wr_i && (addr_i == OFS_CTRL);
  assign wr_data    = wr_i && (addr_i == OFS_DATA);
  assign rd_ctrl    = rd_i && (addr_i == OFS_CTRL);
  assign rd_data    = rd_i && (addr_i == OFS_DATA);
  assign tx_ack     = wr_ctrl && (wdata_i == CMD_TX_ACK);
  assign fifo_empty = (rx_cnt == '0);
  // stream is empty after this read (or already was)
  assign rx_clr     = rd_data && (rx_cnt <= CNT_W'(1));

  cnsl_rx_fifo #(.DW(BUS_W), .DEPTH(RX_DEPTH)) u_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (rx_valid_i),
    .push_data_i (rx_data_i),
    .pop_i       (rd_data),
    .head_o      (fifo_head),
    .count_o     (rx_cnt),
    .drop_o      (fifo_drop)
  );

  cnsl_pend_ctrl u_pend (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tx_set_i  (wr_data),
    .tx_ack_i  (tx_ack),
    .rx_set_i  (rx_valid_i),
    .rx_clr_i  (rx_clr),
    .tx_pend_o (tx_pend),
    .rx_pend_o (rx_pend),
    .irq_o     (irq_o),
    .ack_err_o (ack_err)
  );

  cnsl_rd_mux u_mux (
    .addr_i       (addr_i),
    .ptr_i        (ptr_q),
    .tx_pend_i    (tx_pend),
    .rx_pend_i    (rx_pend),
    .fifo_empty_i (fifo_empty),
    .fifo_head_i  (fifo_head),
    .rdata_o      (rd_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q      <= '0;
      rdata_o    <= '0;
      tx_valid_o <= 1'b0;
      tx_data_o  <= '0;
      err_o      <= 1'b0;
    end else begin
      if (wr_ctrl)                           ptr_q <= wdata_i;
      else if (rd_ctrl && ptr_q == PTR_ISRC) ptr_q <= '0;
      rdata_o    <= rd_i ? rd_val : '0;
      tx_valid_o <= wr_data;
      if (wr_data) tx_data_o <= wdata_i;
      err_o      <= ack_err || (rd_data && fifo_empty) || fifo_drop;
    end
  end
endmodule

// File: rtl/cnsl_chk.sv
module cnsl_chk
  import cnsl_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned CW    = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [7:0]    addr_i,
  input logic          wr_i,
  input logic [7:0]    wdata_i,
  input logic          rd_i,
  input logic [7:0]    rdata_o,
  input logic          rx_valid_i,
  input logic          tx_valid_o,
  input logic [7:0]    tx_data_o,
  input logic          irq_o,
  input logic          err_o,
  input logic          tx_pend,
  input logic [CW-1:0] rx_cnt
);
  // R5
  tx_on_data_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == OFS_DATA) |=> (tx_valid_o && tx_data_o == $past(wdata_i) && irq_o && tx_pend));
  // R7
  rx_raises_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i |=> irq_o);
  // R6
  ack_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == OFS_CTRL && wdata_i == CMD_TX_ACK && !rx_valid_i) |=> (!tx_pend && !irq_o));
  // R9
  empty_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == OFS_DATA && rx_cnt == '0) |=> (err_o && rdata_o == 8'h00));
  // R10
  other_ofs_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i != OFS_CTRL && addr_i != OFS_DATA) |=> (rdata_o == 8'h00));
  // R12
  irq_rise_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(rx_valid_i || (wr_i && addr_i == OFS_DATA)));
  // R13
  idle_rdata_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> (rdata_o == 8'h00));
  // R11
  fifo_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_cnt <= CW'(DEPTH));
endmodule

bind console_port_ctrl cnsl_chk #(.DEPTH(RX_DEPTH), .CW(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .wr_i       (wr_i),
  .wdata_i    (wdata_i),
  .rd_i       (rd_i),
  .rdata_o    (rdata_o),
  .rx_valid_i (rx_valid_i),
  .tx_valid_o (tx_valid_o),
  .tx_data_o  (tx_data_o),
  .irq_o      (irq_o),
  .err_o      (err_o),
  .tx_pend    (tx_pend),
  .rx_cnt     (rx_cnt)
);

// File: tb/tb_console_port_ctrl.sv
module tb_console_port_ctrl;
  localparam int DEPTH = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = '0, wdata = '0, rx_data = '0;
  logic       wr = 1'b0, rd = 1'b0, rx_valid = 1'b0;
  logic [7:0] rdata, tx_data;
  logic       tx_valid, irq, err;

  int checks = 0, fails = 0;
  bit done = 0;

  console_port_ctrl #(.RX_DEPTH(DEPTH)) dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .wdata_i(wdata),
    .rd_i(rd), .rdata_o(rdata), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .irq_o(irq), .err_o(err)
  );

  always #5 clk = ~clk;

  // behavioural reference model
  logic [7:0] m_q[$];
  int         m_ptr;
  bit         m_txp, m_rxp, m_irq;
  logic [7:0] e_rdata, e_txd;
  bit         e_txv, e_err;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q.delete();
      m_ptr = 0; m_txp = 0; m_rxp = 0; m_irq = 0;
      e_rdata = 0; e_txd = 0; e_txv = 0; e_err = 0;
    end else begin
      bit ack, clr;
      ack = 0; clr = 0; e_err = 0; e_rdata = 0;
      e_txv = wr && addr == 8'hC0;
      if (e_txv) e_txd = wdata;
      if (rd && addr == 8'h80) begin
        if (m_ptr == 3) begin
          e_rdata = m_txp ? 8'h10 : (m_rxp ? 8'h20 : 8'h00);
          if (!(wr && addr == 8'h80)) m_ptr = 0;
        end else e_rdata = 8'h04 | {7'd0, m_rxp};
      end else if (rd && addr == 8'hC0) begin
        if (m_q.size() == 0) begin
          e_rdata = 0; e_err = 1; clr = 1;
        end else begin
          e_rdata = m_q.pop_front();
          clr = (m_q.size() == 0);
        end
      end
      if (rx_valid) begin
        if (m_q.size() < DEPTH) m_q.push_back(rx_data);
        else e_err = 1;
      end
      if (wr && addr == 8'h80) begin
        m_ptr = wdata;
        if (wdata == 8'h28) begin
          ack = 1;
          if (!m_txp) e_err = 1;
        end
      end
      m_txp = e_txv ? 1 : (ack ? 0 : m_txp);
      m_rxp = rx_valid ? 1 : (clr ? 0 : m_rxp);
      m_irq = (e_txv || rx_valid) ? 1 : ((ack || clr) ? 0 : m_irq);
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h t=%0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) if (rst_n && !done) begin
    chk("R13 rdata", rdata, e_rdata);
    chk("R12 irq", {7'd0, irq}, {7'd0, m_irq});
    chk("R5 tx_valid", {7'd0, tx_valid}, {7'd0, e_txv});
    if (e_txv) chk("R5 tx_data", tx_data, e_txd);
    chk("R11 err", {7'd0, err}, {7'd0, e_err});
  end

  task automatic cyc(input bit r, input bit w, input logic [7:0] a, input logic [7:0] d,
                     input bit rv, input logic [7:0] rdv);
    @(negedge clk);
    rd = r; wr = w; addr = a; wdata = d; rx_valid = rv; rx_data = rdv;
    @(negedge clk);
    rd = 0; wr = 0; rx_valid = 0;
  endtask

  task automatic wreg(input logic [7:0] a, input logic [7:0] d);
    cyc(0, 1, a, d, 0, 0);
  endtask

  task automatic rreg(input string req, input logic [7:0] a, input logic [7:0] exp);
    cyc(1, 0, a, 0, 0, 0);
    chk(req, rdata, exp);
  endtask

  task automatic push(input logic [7:0] d);
    cyc(0, 0, 0, 0, 1, d);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 err", {7'd0, err}, 8'h00);
    chk("R1 tx_valid", {7'd0, tx_valid}, 8'h00);
    rst_n = 1;
    rreg("R1 status", 8'h80, 8'h04);

    // R5 transmit, R3 tx code, R2 pointer auto-reset
    wreg(8'hC0, 8'h41);
    chk("R5 irq", {7'd0, irq}, 8'h01);
    rreg("R4 status no rx", 8'h80, 8'h04);
    wreg(8'h80, 8'h03);
    rreg("R3 tx code", 8'h80, 8'h10);
    rreg("R2 ptr reset", 8'h80, 8'h04);

    // R6 acknowledge, then spurious acknowledge
    wreg(8'h80, 8'h28);
    chk("R6 irq cleared", {7'd0, irq}, 8'h00);
    cyc(0, 1, 8'h80, 8'h28, 0, 0);
    // err pulse of spurious ack already visible at this negedge (checked by model too)
    wreg(8'h80, 8'h12);
    rreg("R2 ptr 0x12", 8'h80, 8'h04);
    wreg(8'h80, 8'h01);
    rreg("R2 ptr 0x01", 8'h80, 8'h04);

    // R7 receive, R4 bit0, R3 rx code, R8 order and clearing
    push(8'h55);
    chk("R7 irq", {7'd0, irq}, 8'h01);
    rreg("R4 status rx", 8'h80, 8'h05);
    wreg(8'h80, 8'h03);
    rreg("R3 rx code", 8'h80, 8'h20);
    push(8'h66);
    rreg("R8 first", 8'hC0, 8'h55);
    chk("R8 irq kept", {7'd0, irq}, 8'h01);
    rreg("R8 second", 8'hC0, 8'h66);
    chk("R8 irq cleared", {7'd0, irq}, 8'h00);
    wreg(8'h80, 8'h03);
    rreg("R3 none", 8'h80, 8'h00);

    // R9 empty read
    rreg("R9 empty", 8'hC0, 8'h00);
    chk("R9 err", {7'd0, err}, 8'h01);

    // R3 priority and R6 ack leaves rx pending
    push(8'h11);
    wreg(8'hC0, 8'h22);
    wreg(8'h80, 8'h03);
    rreg("R3 priority", 8'h80, 8'h10);
    wreg(8'h80, 8'h28);
    chk("R6 irq off with rx", {7'd0, irq}, 8'h00);
    wreg(8'h80, 8'h03);
    rreg("R3 rx after ack", 8'h80, 8'h20);
    rreg("R8 pop", 8'hC0, 8'h11);

    // R10 other offsets
    rreg("R10 read 00", 8'h00, 8'h00);
    rreg("R10 read 81", 8'h81, 8'h00);
    wreg(8'h40, 8'h03);
    chk("R10 no tx", {7'd0, tx_valid}, 8'h00);
    rreg("R10 ptr kept", 8'h80, 8'h04);

    // R11 overflow
    for (int i = 0; i < DEPTH; i++) push(8'hA0 + 8'(i));
    push(8'h99);
    chk("R11 drop err", {7'd0, err}, 8'h01);
    for (int i = 0; i < DEPTH; i++) rreg("R11 order", 8'hC0, 8'hA0 + 8'(i));
    rreg("R11 dropped", 8'hC0, 8'h00);

    // R12 arrival with emptying read
    push(8'h31);
    cyc(1, 0, 8'hC0, 0, 1, 8'h77);
    chk("R12 rdata", rdata, 8'h31);
    chk("R12 irq held", {7'd0, irq}, 8'h01);
    rreg("R12 next", 8'hC0, 8'h77);
    wreg(8'hC0, 8'h5A);
    cyc(0, 1, 8'h80, 8'h28, 1, 8'h33);
    chk("R12 ack vs rx", {7'd0, irq}, 8'h01);
    rreg("R12 drain", 8'hC0, 8'h33);

    // pseudo-random mix against model
    begin
      logic [15:0] lf = 16'hACE1;
      for (int n = 0; n < 3000; n++) begin
        logic [7:0] a, d;
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        case (lf[2:1])
          2'd0: a = 8'h80;
          2'd1: a = 8'hC0;
          2'd2: a = 8'hC0;
          default: a = lf[9:2];
        endcase
        d = lf[3] ? 8'h28 : (lf[4] ? 8'h03 : lf[15:8]);
        @(negedge clk);
        rd = lf[0] && !lf[5];
        wr = !rd && lf[6];
        addr = a; wdata = d;
        rx_valid = lf[7] && lf[11];
        rx_data = lf[14:7];
      end
      @(negedge clk);
      rd = 0; wr = 0; rx_valid = 0;
      repeat (2) @(negedge clk);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule